// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block joins two eight-line priority interrupt controllers, a primary and a secondary, into one sixteen-line system. Lines 0 to 7 are owned by the primary controller and lines 8 to 15 by the secondary. Whenever the secondary holds a deliverable request, it raises a request on primary line 2, its cascade input. The primary's own pin for line 2 is not used as a request source. The CPU interrupt output follows the primary's deliverable state.

When the CPU pulses its acknowledge strobe, the block resolves the primary winner. If that winner is the cascade line, it goes on to resolve the secondary winner. It then updates the in-service, request and rotation state of each controller it touched. One cycle later it presents an 8-bit vector together with a one-cycle valid strobe. A fixed fallback to line 7 covers the case where either controller has nothing to deliver.

Configuration is supplied as plain inputs: masks, vector bases, end-of-interrupt mode, a trigger-select write port, end-of-interrupt strobes and a re-initialise strobe.

Top module: `cascade_ack_seq`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `cpu_int` and `vec_valid` are 0.
- R2: The vector is {base[7:3], line[2:0]}. The low three bits of `base_m` and `base_s` are ignored. Bit 3 of a system line number selects the secondary controller.
- R3: A deliverable secondary request sets the primary's line 2 request, so `cpu_int` rises. The `irq_in[2]` pin never raises a request.
- R4: If the primary has nothing deliverable when `inta` is pulsed, the vector is base_m + 7.
- R5: If the primary winner is line 2 but the secondary has nothing deliverable, the vector is base_s + 7.
- R6: With `aeoi`=0, an acknowledge sets the winner's in-service bit. That blocks requests of equal or lower priority until an `eoi_m`/`eoi_s` pulse clears the highest-priority in-service bit.
- R7: With `aeoi`=1, no in-service bit is set. If `rot_aeoi`=1 as well, the acknowledged line+1 (mod 8) becomes the highest priority.
- R8: An acknowledge clears the request of an edge-triggered line. A level-triggered line stays requested.
- R9: For an edge line (trigger bit 0), a rising edge latches the request even after the pin falls.
- R10: For a level line (trigger bit 1), the request follows the pin level.
- R11: A trigger write (`trig_sel` 0 = primary, 1 = secondary) is ANDed with 0xF8 for the primary and 0xDE for the secondary.
- R12: `reinit` clears requests, in-service bits and rotation, and keeps the trigger selection.
- R13: With no rotation, the lower line number wins. A line whose mask bit is 1 is not delivered.
- R14: `vec_valid` is high exactly in the cycle after an `inta` cycle. `cpu_int` reflects state changes one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reinit | input | 1 | Re-initialise both controllers (trigger kept) |
| irq_in | input | 16 | Interrupt lines; [7:0] primary, [15:8] secondary |
| imr_m | input | 8 | Primary mask, 1 = blocked |
| imr_s | input | 8 | Secondary mask, 1 = blocked |
| base_m | input | 8 | Primary vector base |
| base_s | input | 8 | Secondary vector base |
| aeoi | input | 1 | Automatic end of interrupt |
| rot_aeoi | input | 1 | Rotate priority on automatic end of interrupt |
| trig_wr | input | 1 | Trigger-select write strobe |
| trig_sel | input | 1 | 0 = primary, 1 = secondary |
| trig_data | input | 8 | Trigger bits, 1 = level |
| eoi_m | input | 1 | Non-specific end of interrupt, primary |
| eoi_s | input | 1 | Non-specific end of interrupt, secondary |
| inta | input | 1 | CPU acknowledge strobe |
| cpu_int | output | 1 | Interrupt request to the CPU |
| vec_valid | output | 1 | Vector strobe |
| vec_out | output | 8 | Acknowledge vector |

## Verification
The hardest state to reach is the secondary spurious case. The primary must hold a latched cascade request while the secondary no longer has anything to deliver. The stimulus gets there by making a secondary line level-triggered and raising it until the cascade request latches on the primary, which is always edge-triggered on line 2. It then drops the line before acknowledging. The rotation case is also reached only through a sequence: one automatic-EOI acknowledge moves the priority base, and a re-raised lower line must then lose to a higher-numbered one.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_LINES = 8;
  localparam int PIC_LW    = $clog2(PIC_LINES);
  localparam int VEC_W     = 8;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [LW-1:0] rot,
  output logic          hit,
  output logic [LW-1:0] rank
);
  always_comb begin
    hit  = 1'b0;
    rank = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[(k + int'(rot)) % N]) begin
        hit  = 1'b1;
        rank = LW'(k);
      end
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core #(
  parameter int          N         = pic_pkg::PIC_LINES,
  parameter int          LW        = pic_pkg::PIC_LW,
  parameter logic [N-1:0] TRIG_MASK = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reinit,
  input  logic [N-1:0]  lines,
  input  logic [N-1:0]  force_set,
  input  logic [N-1:0]  imr,
  input  logic          trig_wr,
  input  logic [N-1:0]  trig_data,
  input  logic          aeoi,
  input  logic          rot_aeoi,
  input  logic          eoi,
  input  logic          ack,
  output logic          deliv,
  output logic [LW-1:0] win_line
);
  logic [N-1:0]  irr, isr, prev, trig;
  logic [LW-1:0] rot;
  logic [N-1:0]  pend;
  logic          r_hit, s_hit;
  logic [LW-1:0] r_rank, s_rank, eoi_line;

  assign pend = irr & ~imr;

  pic_prio #(.N(N), .LW(LW)) u_req (.req(pend), .rot(rot), .hit(r_hit), .rank(r_rank));
  pic_prio #(.N(N), .LW(LW)) u_svc (.req(isr),  .rot(rot), .hit(s_hit), .rank(s_rank));

  assign deliv    = r_hit && (!s_hit || (r_rank < s_rank));
  assign win_line = r_rank + rot;
  assign eoi_line = s_rank + rot;

  generate
    for (genvar i = 0; i < N; i++) begin : g_line
      localparam logic [LW-1:0] IDX = LW'(i);
      always_ff @(posedge clk) begin
        if (rst || reinit) begin
          irr[i]  <= 1'b0;
          prev[i] <= 1'b0;
        end else begin
          prev[i] <= lines[i];
          if (trig[i])
            irr[i] <= lines[i];
          else if ((lines[i] && !prev[i]) || force_set[i])
            irr[i] <= 1'b1;
          else if (ack && win_line == IDX)
            irr[i] <= 1'b0;
        end
      end
      always_ff @(posedge clk) begin
        if (rst || reinit)
          isr[i] <= 1'b0;
        else if (ack && !aeoi && win_line == IDX)
          isr[i] <= 1'b1;
        else if (eoi && s_hit && eoi_line == IDX)
          isr[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || reinit)
      rot <= '0;
    else if (ack && aeoi && rot_aeoi)
      rot <= win_line + LW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)
      trig <= '0;
    else if (trig_wr)
      trig <= trig_data & TRIG_MASK;
  end

  // R7
  aeoi_isr_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && aeoi && !eoi && !reinit) |=> (isr == $past(isr)));

  // R12
  trig_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (reinit && !trig_wr) |=> (trig == $past(trig)));
endmodule

// File: rtl/cascade_ack_seq.sv
module cascade_ack_seq #(
  parameter logic [7:0] M_TRIG_MASK = 8'hF8,
  parameter logic [7:0] S_TRIG_MASK = 8'hDE,
  parameter int         CAS_LINE    = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reinit,
  input  logic [15:0] irq_in,
  input  logic [7:0]  imr_m,
  input  logic [7:0]  imr_s,
  input  logic [7:0]  base_m,
  input  logic [7:0]  base_s,
  input  logic        aeoi,
  input  logic        rot_aeoi,
  input  logic        trig_wr,
  input  logic        trig_sel,
  input  logic [7:0]  trig_data,
  input  logic        eoi_m,
  input  logic        eoi_s,
  input  logic        inta,
  output logic        cpu_int,
  output logic        vec_valid,
  output logic [7:0]  vec_out
);
  import pic_pkg::*;
  localparam int N  = PIC_LINES;
  localparam int LW = PIC_LW;
  localparam logic [N-1:0]  CAS_BIT = N'(1) << CAS_LINE;
  localparam logic [LW-1:0] CAS_IDX = LW'(CAS_LINE);
  localparam logic [LW-1:0] SPUR    = '1;

  logic          m_deliv, s_deliv, ack_m, ack_s;
  logic [LW-1:0] m_line, s_line;
  logic [N-1:0]  m_lines, m_force;
  logic [VEC_W-1:0] vec_d;

  assign ack_m   = inta && m_deliv;
  assign ack_s   = ack_m && (m_line == CAS_IDX) && s_deliv;
  assign m_lines = irq_in[N-1:0] & ~CAS_BIT;
  assign m_force = (s_deliv && !ack_m) ? CAS_BIT : '0;

  pic_core #(.N(N), .LW(LW), .TRIG_MASK(M_TRIG_MASK)) u_master (
    .clk(clk), .rst(rst), .reinit(reinit), .lines(m_lines), .force_set(m_force),
    .imr(imr_m), .trig_wr(trig_wr && !trig_sel), .trig_data(trig_data),
    .aeoi(aeoi), .rot_aeoi(rot_aeoi), .eoi(eoi_m), .ack(ack_m),
    .deliv(m_deliv), .win_line(m_line));

  pic_core #(.N(N), .LW(LW), .TRIG_MASK(S_TRIG_MASK)) u_slave (
    .clk(clk), .rst(rst), .reinit(reinit), .lines(irq_in[2*N-1:N]), .force_set('0),
    .imr(imr_s), .trig_wr(trig_wr && trig_sel), .trig_data(trig_data),
    .aeoi(aeoi), .rot_aeoi(rot_aeoi), .eoi(eoi_s), .ack(ack_s),
    .deliv(s_deliv), .win_line(s_line));

  always_comb begin
    if (!ack_m)
      vec_d = {base_m[VEC_W-1:LW], SPUR};
    else if (m_line == CAS_IDX)
      vec_d = {base_s[VEC_W-1:LW], (s_deliv ? s_line : SPUR)};
    else
      vec_d = {base_m[VEC_W-1:LW], m_line};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_int   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      cpu_int   <= m_deliv;
      vec_valid <= inta;
      if (inta) vec_out <= vec_d;
    end
  end

  // R14
  strobe_on_chk: assert property (@(posedge clk) disable iff (rst)
    inta |=> vec_valid);
  // R14
  strobe_off_chk: assert property (@(posedge clk) disable iff (rst)
    !inta |=> !vec_valid);
  // R4
  spur_low_chk: assert property (@(posedge clk) disable iff (rst)
    (inta && !m_deliv) |=> (vec_out[LW-1:0] == SPUR));
endmodule

// File: tb/sim_cascade_ack_seq.sv
module sim_cascade_ack_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reinit = 0, aeoi = 0, rot_aeoi = 0, trig_wr = 0, trig_sel = 0;
  logic eoi_m = 0, eoi_s = 0, inta = 0;
  logic [15:0] irq_in = '0;
  logic [7:0] imr_m = '0, imr_s = '0, trig_data = '0;
  logic [7:0] base_m = 8'h27, base_s = 8'h70;
  logic cpu_int, vec_valid;
  logic [7:0] vec_out;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cascade_ack_seq u0 (
    .clk(clk), .rst(rst), .reinit(reinit), .irq_in(irq_in), .imr_m(imr_m),
    .imr_s(imr_s), .base_m(base_m), .base_s(base_s), .aeoi(aeoi),
    .rot_aeoi(rot_aeoi), .trig_wr(trig_wr), .trig_sel(trig_sel),
    .trig_data(trig_data), .eoi_m(eoi_m), .eoi_s(eoi_s), .inta(inta),
    .cpu_int(cpu_int), .vec_valid(vec_valid), .vec_out(vec_out));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int line);
    @(negedge clk) irq_in[line] = 1'b1;
    @(negedge clk) irq_in[line] = 1'b0;
  endtask

  task automatic do_ack(input logic [7:0] exp, input string req);
    @(negedge clk) inta = 1'b1;
    @(negedge clk) inta = 1'b0;
    chk(vec_valid == 1'b1, "R14", vec_valid, 1);
    chk(vec_out == exp, req, vec_out, exp);
    @(negedge clk);
    chk(vec_valid == 1'b0, "R14", vec_valid, 0);
  endtask

  task automatic strobe_eoi(input bit sec);
    @(negedge clk) begin eoi_m = !sec; eoi_s = sec; end
    @(negedge clk) begin eoi_m = 0; eoi_s = 0; end
  endtask

  task automatic trig_write(input bit sec, input logic [7:0] d);
    @(negedge clk) begin trig_wr = 1; trig_sel = sec; trig_data = d; end
    @(negedge clk) trig_wr = 0;
  endtask

  task automatic t_reset;
    chk(cpu_int == 0, "R1", cpu_int, 0);
    chk(vec_valid == 0, "R1", vec_valid, 0);
  endtask

  task automatic t_nested;
    @(negedge clk) begin irq_in[5] = 1; irq_in[3] = 1; end
    @(negedge clk) begin irq_in[5] = 0; irq_in[3] = 0; end
    tick(3);
    chk(cpu_int == 1, "R9", cpu_int, 1);
    do_ack(8'h23, "R13");
    tick(2);
    chk(cpu_int == 0, "R6", cpu_int, 0);
    strobe_eoi(0);
    tick(2);
    chk(cpu_int == 1, "R6", cpu_int, 1);
    do_ack(8'h25, "R2");
    strobe_eoi(0);
    tick(2);
    chk(cpu_int == 0, "R6", cpu_int, 0);
  endtask

  task automatic t_mask;
    imr_m = 8'h08;
    pulse(3);
    tick(3);
    chk(cpu_int == 0, "R13", cpu_int, 0);
    imr_m = 8'h00;
    tick(3);
    chk(cpu_int == 1, "R13", cpu_int, 1);
    do_ack(8'h23, "R13");
    strobe_eoi(0);
  endtask

  task automatic t_spur_m;
    tick(2);
    do_ack(8'h27, "R4");
  endtask

  task automatic t_cascade;
    pulse(2);
    tick(4);
    chk(cpu_int == 0, "R3", cpu_int, 0);
    pulse(12);
    tick(4);
    chk(cpu_int == 1, "R3", cpu_int, 1);
    do_ack(8'h74, "R3");
    strobe_eoi(1);
    strobe_eoi(0);
    tick(3);
    chk(cpu_int == 0, "R3", cpu_int, 0);
  endtask

  task automatic t_spur_s;
    trig_write(1, 8'h02);
    @(negedge clk) irq_in[9] = 1;
    tick(4);
    chk(cpu_int == 1, "R5", cpu_int, 1);
    @(negedge clk) irq_in[9] = 0;
    tick(3);
    chk(cpu_int == 1, "R5", cpu_int, 1);
    do_ack(8'h77, "R5");
    strobe_eoi(0);
    trig_write(1, 8'h00);
    tick(2);
  endtask

  task automatic t_rotate;
    aeoi = 1; rot_aeoi = 1;
    @(negedge clk) begin irq_in[5] = 1; irq_in[3] = 1; end
    @(negedge clk) begin irq_in[5] = 0; irq_in[3] = 0; end
    tick(2);
    do_ack(8'h23, "R7");
    pulse(3);
    tick(2);
    do_ack(8'h25, "R7");
    do_ack(8'h23, "R7");
    do_ack(8'h27, "R7");
    @(negedge clk) reinit = 1;
    @(negedge clk) reinit = 0;
    rot_aeoi = 0;
  endtask

  task automatic t_level_edge;
    trig_write(0, 8'h10);
    @(negedge clk) irq_in[4] = 1;
    tick(2);
    do_ack(8'h24, "R8");
    do_ack(8'h24, "R8");
    @(negedge clk) irq_in[4] = 0;
    tick(2);
    do_ack(8'h27, "R10");
    pulse(6);
    tick(2);
    do_ack(8'h26, "R8");
    do_ack(8'h27, "R8");
  endtask

  task automatic t_trig_mask;
    trig_write(0, 8'hFF);
    pulse(1);
    tick(3);
    do_ack(8'h21, "R11");
    trig_write(1, 8'hFF);
    pulse(8);
    tick(4);
    do_ack(8'h70, "R11");
  endtask

  task automatic t_reinit;
    pulse(1);
    @(negedge clk) reinit = 1;
    @(negedge clk) reinit = 0;
    tick(2);
    do_ack(8'h27, "R12");
    @(negedge clk) irq_in[4] = 1;
    tick(2);
    @(negedge clk) irq_in[4] = 0;
    tick(2);
    do_ack(8'h27, "R12");
  endtask

  initial begin
    tick(3);
    t_reset;
    @(negedge clk) rst = 0;
    @(negedge clk);
    t_reset;
    t_nested;
    t_mask;
    t_spur_m;
    t_cascade;
    t_spur_s;
    t_rotate;
    t_level_edge;
    t_trig_mask;
    t_reinit;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule